// File: doc/BRIEF.md
# Packed Subword Rearrangement Unit

This block reorders the 16-bit subwords held in packed 64-bit operands. It does no arithmetic. It has two kinds of operation:

- **Permute** takes one source and builds any arrangement of its four lanes. A lane may appear more than once, so one element can be broadcast to every lane.
- **Mix** interleaves alternate subwords of two sources, in groups of one lane (16 bits) or two lanes (32 bits). The left variant takes the even groups and the right variant takes the odd groups.

Mix operations are enough to transpose an n-by-n matrix of subwords in log2(n) steps. With an all-zero operand they widen packed data and then narrow it back.

Each accepted operation is captured by the output register. Its result appears one clock later, together with a valid flag. When no operation is accepted, the previous result stays on the output.

Top module: `swr_unit`

## Requirements
- R1: While reset is asserted and after it is released, before the first accepted operation, `out_valid` is 0 and `result` is all zeros.
- R2: `out_valid` equals the value `in_valid` had one clock earlier. The result of an operation accepted at a rising edge is on `result` after that same edge.
- R3: When `in_valid` is 0 at a rising edge, `result` keeps its value.
- R4: For opcode 1 (permute), result lane k is the `src_a` lane numbered by field k of `perm_sel`. Field k sits at bits [2k+1:2k], and lane 0 is the leftmost lane, bits [63:48]. Lane k occupies bits [63-16k : 48-16k].
- R5: Under permute, `src_b` has no effect on the result.
- R6: Opcode 2 (mix-left, 16-bit) gives (a0, b0, a2, b2).
- R7: Opcode 3 (mix-right, 16-bit) gives (a1, b1, a3, b3).
- R8: Opcode 4 (mix-left, 32-bit) gives (a0, a1, b0, b1).
- R9: Opcode 5 (mix-right, 32-bit) gives (a2, a3, b2, b3).
- R10: Opcodes 0, 6 and 7 pass `src_a` through unchanged.
- R11: Four 16-bit mixes followed by four 32-bit mixes, applied to four rows, yield the transpose of the 4x4 matrix.
- R12: A 16-bit mix against a zero operand spreads subwords apart, with the zeros to the right or to the left depending on operand order. A following mix-left-16 of the two halves restores the original word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation accepted this cycle |
| opcode | input | 3 | Operation code |
| src_a | input | 64 | First source |
| src_b | input | 64 | Second source |
| perm_sel | input | 8 | Four 2-bit lane selectors for permute |
| out_valid | output | 1 | Result of last cycle's operation is present |
| result | output | 64 | Registered result |

## Verification
The only internal state is the output register and the valid flag. A fault in either shows at the ports on the edge right after the faulty operation. A swapped lane index or group offset, or a wrong operand choice, puts the wrong subword in a specific lane on the next cycle.

Random sources make every lane distinct, so any misrouting changes the compared word. A missing hold enable breaks the result during the idle cycles that follow each operation.

// File: rtl/swr_pkg.sv
package swr_pkg;
  localparam int NUM_LANES = 4;
  localparam int SEL_W     = 2;
  localparam int OP_W      = 3;

  typedef enum logic [OP_W-1:0] {
    OP_PASS   = 3'd0,
    OP_PERM   = 3'd1,
    OP_MIXL16 = 3'd2,
    OP_MIXR16 = 3'd3,
    OP_MIXL32 = 3'd4,
    OP_MIXR32 = 3'd5
  } swr_op_e;
endpackage

// File: rtl/swr_permute.sv
module swr_permute #(
  parameter int LANE_W = 16
) (
  input  logic [swr_pkg::NUM_LANES*LANE_W-1:0]   src,
  input  logic [swr_pkg::NUM_LANES*swr_pkg::SEL_W-1:0] sel,
  output logic [swr_pkg::NUM_LANES*LANE_W-1:0]   dst
);
  localparam int NL = swr_pkg::NUM_LANES;
  localparam int SW = swr_pkg::SEL_W;
  localparam int WW = NL * LANE_W;

  // lane 0 is the leftmost subword
  function automatic logic [LANE_W-1:0] lane_of(input logic [WW-1:0] w, input int idx);
    return w[(NL-1-idx)*LANE_W +: LANE_W];
  endfunction

  for (genvar k = 0; k < NL; k++) begin : g_lane
    logic [SW-1:0] pick;
    assign pick = sel[k*SW +: SW];
    assign dst[(NL-1-k)*LANE_W +: LANE_W] = lane_of(src, int'(pick));
  end
endmodule

// File: rtl/swr_mix.sv
module swr_mix #(
  parameter int LANE_W = 16,
  parameter int GROUP  = 1,  // lanes per interleaved group
  parameter bit RIGHT  = 0   // 0: even groups, 1: odd groups
) (
  input  logic [swr_pkg::NUM_LANES*LANE_W-1:0] a,
  input  logic [swr_pkg::NUM_LANES*LANE_W-1:0] b,
  output logic [swr_pkg::NUM_LANES*LANE_W-1:0] y
);
  localparam int NL    = swr_pkg::NUM_LANES;
  localparam int GW    = GROUP * LANE_W;
  localparam int NG    = NL / GROUP;
  localparam int WW    = NL * LANE_W;
  localparam int OFF   = RIGHT ? 1 : 0;

  function automatic logic [GW-1:0] group_of(input logic [WW-1:0] w, input int g);
    return w[(NG-1-g)*GW +: GW];
  endfunction

  for (genvar j = 0; j < NG; j++) begin : g_grp
    localparam int SRC_G = 2*(j/2) + OFF;
    if (j % 2 == 0) begin : g_from_a
      assign y[(NG-1-j)*GW +: GW] = group_of(a, SRC_G);
    end else begin : g_from_b
      assign y[(NG-1-j)*GW +: GW] = group_of(b, SRC_G);
    end
  end
endmodule

// File: rtl/swr_out_stage.sv
module swr_out_stage #(
  parameter int WW = 64
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        take,
  input  logic [swr_pkg::OP_W-1:0]    op,
  input  logic [WW-1:0]               pass_v,
  input  logic [WW-1:0]               perm_v,
  input  logic [WW-1:0]               ml16_v,
  input  logic [WW-1:0]               mr16_v,
  input  logic [WW-1:0]               ml32_v,
  input  logic [WW-1:0]               mr32_v,
  output logic                        vld_q,
  output logic [WW-1:0]               res_q
);
  import swr_pkg::*;
  logic [WW-1:0] chosen;

  always_comb begin
    case (op)
      OP_PERM:   chosen = perm_v;
      OP_MIXL16: chosen = ml16_v;
      OP_MIXR16: chosen = mr16_v;
      OP_MIXL32: chosen = ml32_v;
      OP_MIXR32: chosen = mr32_v;
      default:   chosen = pass_v;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      res_q <= '0;
    end else begin
      vld_q <= take;
      if (take) res_q <= chosen;
    end
  end
endmodule

// File: rtl/swr_unit.sv
module swr_unit #(
  parameter int LANE_W = 16,
  localparam int WW = swr_pkg::NUM_LANES * LANE_W,
  localparam int PS = swr_pkg::NUM_LANES * swr_pkg::SEL_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic [swr_pkg::OP_W-1:0] opcode,
  input  logic [WW-1:0]            src_a,
  input  logic [WW-1:0]            src_b,
  input  logic [PS-1:0]            perm_sel,
  output logic                     out_valid,
  output logic [WW-1:0]            result
);
  logic [WW-1:0] perm_w;
  logic [WW-1:0] mix_w [4];

  swr_permute #(.LANE_W(LANE_W)) u_perm (
    .src(src_a), .sel(perm_sel), .dst(perm_w)
  );

  // variants: 0 L16, 1 R16, 2 L32, 3 R32
  for (genvar v = 0; v < 4; v++) begin : g_mix
    swr_mix #(.LANE_W(LANE_W), .GROUP(v/2 + 1), .RIGHT(v % 2)) u_mix (
      .a(src_a), .b(src_b), .y(mix_w[v])
    );
  end

  swr_out_stage #(.WW(WW)) u_out (
    .clk(clk), .rst_n(rst_n), .take(in_valid), .op(opcode),
    .pass_v(src_a), .perm_v(perm_w),
    .ml16_v(mix_w[0]), .mr16_v(mix_w[1]),
    .ml32_v(mix_w[2]), .mr32_v(mix_w[3]),
    .vld_q(out_valid), .res_q(result)
  );
endmodule

// File: rtl/swr_unit_chk.sv
module swr_unit_chk #(
  parameter int LANE_W = 16,
  localparam int WW = 4 * LANE_W
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic [2:0]    opcode,
  input logic [WW-1:0] src_a,
  input logic [WW-1:0] src_b,
  input logic [7:0]    perm_sel,
  input logic          out_valid,
  input logic [WW-1:0] result
);
  localparam int L = LANE_W;

  p_valid_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_valid_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result));
  p_perm_lane0_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode == 3'd1) |=>
      result[WW-1 -: L] == $past(src_a[(3 - perm_sel[1:0])*L +: L]));
  p_mixl16_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode == 3'd2) |=>
      result[WW-1 -: 2*L] == {$past(src_a[WW-1 -: L]), $past(src_b[WW-1 -: L])});
  p_mixr32_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode == 3'd5) |=>
      result == {$past(src_a[2*L-1:0]), $past(src_b[2*L-1:0])});
  p_pass_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (opcode == 3'd0 || opcode > 3'd5)) |=> result == $past(src_a));
endmodule

bind swr_unit swr_unit_chk #(.LANE_W(LANE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
  .src_a(src_a), .src_b(src_b), .perm_sel(perm_sel),
  .out_valid(out_valid), .result(result)
);

// File: tb/swr_unit_tb.sv
module swr_unit_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [2:0] opcode = '0;
  logic [63:0] src_a = '0, src_b = '0;
  logic [7:0] perm_sel = '0;
  logic out_valid;
  logic [63:0] result;
  int total = 0, bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  swr_unit dut_i (.*);

  function automatic logic [15:0] ln(input logic [63:0] w, input int k);
    return w[63-16*k -: 16];
  endfunction

  function automatic logic [63:0] pk(input logic [15:0] l0, l1, l2, l3);
    return {l0, l1, l2, l3};
  endfunction

  function automatic logic [63:0] model(input logic [2:0] op, input logic [63:0] a, b,
                                        input logic [7:0] s);
    case (op)
      3'd1: return pk(ln(a, s[1:0]), ln(a, s[3:2]), ln(a, s[5:4]), ln(a, s[7:6]));
      3'd2: return pk(ln(a,0), ln(b,0), ln(a,2), ln(b,2));
      3'd3: return pk(ln(a,1), ln(b,1), ln(a,3), ln(b,3));
      3'd4: return pk(ln(a,0), ln(a,1), ln(b,0), ln(b,1));
      3'd5: return pk(ln(a,2), ln(a,3), ln(b,2), ln(b,3));
      default: return a;
    endcase
  endfunction

  task automatic check(input string req, input logic [63:0] act, exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run(input logic [2:0] op, input logic [63:0] a, b,
                     input logic [7:0] s, output logic [63:0] r);
    @(negedge clk);
    opcode = op; src_a = a; src_b = b; perm_sel = s; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R2 out_valid", {63'd0, out_valid}, 64'd1);
    r = result;
    // idle cycle: inputs scrambled, output must hold
    src_a = ~a; src_b = ~b; opcode = 3'd2;
    @(negedge clk);
    check("R3 hold", result, r);
    check("R2 valid low", {63'd0, out_valid}, 64'd0);
  endtask

  task automatic op_chk(input string req, input logic [2:0] op, input logic [63:0] a, b,
                        input logic [7:0] s);
    logic [63:0] r;
    run(op, a, b, s, r);
    check(req, r, model(op, a, b, s));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] r, t1, t2, u1, u2, c1, c2, c3, c4, ra, rb;
    logic [63:0] x, m;
    logic [63:0] rows [4];
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1 reset valid", {63'd0, out_valid}, 64'd0);
    check("R1 reset result", result, 64'd0);
    rst_n = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R1 after release", {out_valid, result[62:0]}, 64'd0);

    x = 64'hAAAA_BBBB_CCCC_DDDD;
    run(3'd1, x, 64'h0, 8'b01_01_01_01, r);
    check("R4 broadcast", r, pk(16'hBBBB, 16'hBBBB, 16'hBBBB, 16'hBBBB));
    run(3'd1, x, 64'h0, 8'b00_01_10_11, r);
    check("R4 reverse", r, pk(16'hDDDD, 16'hCCCC, 16'hBBBB, 16'hAAAA));
    run(3'd1, x, 64'h0, 8'b01_11_10_11, r);
    check("R4 repeat", r, pk(16'hDDDD, 16'hCCCC, 16'hDDDD, 16'hBBBB));
    run(3'd1, x, 64'hFFFF_0123_4567_89AB, 8'b01_11_10_11, r);
    check("R5 src_b ignored", r, pk(16'hDDDD, 16'hCCCC, 16'hDDDD, 16'hBBBB));
    m = 64'h1111_2222_3333_4444;
    run(3'd2, x, m, 8'h0, r); check("R6 mixl16", r, 64'hAAAA_1111_CCCC_3333);
    run(3'd3, x, m, 8'h0, r); check("R7 mixr16", r, 64'hBBBB_2222_DDDD_4444);
    run(3'd4, x, m, 8'h0, r); check("R8 mixl32", r, 64'hAAAA_BBBB_1111_2222);
    run(3'd5, x, m, 8'h0, r); check("R9 mixr32", r, 64'hCCCC_DDDD_3333_4444);
    run(3'd0, x, m, 8'hFF, r); check("R10 op0", r, x);
    run(3'd6, x, m, 8'hFF, r); check("R10 op6", r, x);
    run(3'd7, x, m, 8'hFF, r); check("R10 op7", r, x);

    // R11 transpose
    for (int i = 0; i < 4; i++)
      rows[i] = pk(16'(16*(i+1)+1), 16'(16*(i+1)+2), 16'(16*(i+1)+3), 16'(16*(i+1)+4));
    run(3'd2, rows[0], rows[1], 8'h0, t1);
    run(3'd3, rows[0], rows[1], 8'h0, t2);
    run(3'd2, rows[2], rows[3], 8'h0, u1);
    run(3'd3, rows[2], rows[3], 8'h0, u2);
    run(3'd4, t1, u1, 8'h0, c1);
    run(3'd4, t2, u2, 8'h0, c2);
    run(3'd5, t1, u1, 8'h0, c3);
    run(3'd5, t2, u2, 8'h0, c4);
    check("R11 col1", c1, pk(ln(rows[0],0), ln(rows[1],0), ln(rows[2],0), ln(rows[3],0)));
    check("R11 col2", c2, pk(ln(rows[0],1), ln(rows[1],1), ln(rows[2],1), ln(rows[3],1)));
    check("R11 col3", c3, pk(ln(rows[0],2), ln(rows[1],2), ln(rows[2],2), ln(rows[3],2)));
    check("R11 col4", c4, pk(ln(rows[0],3), ln(rows[1],3), ln(rows[2],3), ln(rows[3],3)));

    // R12 unpack / repack
    run(3'd2, x, 64'h0, 8'h0, ra);
    check("R12 zeros right", ra, 64'hAAAA_0000_CCCC_0000);
    run(3'd3, x, 64'h0, 8'h0, rb);
    run(3'd2, ra, rb, 8'h0, r);
    check("R12 repack", r, x);
    run(3'd2, 64'h0, x, 8'h0, r);
    check("R12 zeros left", r, 64'h0000_AAAA_0000_CCCC);

    // random mix, R4 R6 R7 R8 R9 R10
    for (int n = 0; n < 300; n++) begin
      logic [63:0] a, b;
      a = {$urandom, $urandom};
      b = {$urandom, $urandom};
      op_chk("R4-R10 random op", 3'($urandom), a, b, 8'($urandom));
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule